// File: doc/BRIEF.md
# Stage-2 Stream Entry Validator

This block receives one stream table entry as a flat vector of 32-bit words. Alongside it come the translation unit's capability bits: stage-1 present, stage-2 present, and the maximum output-size code. From the entry it decodes the stage-2 translation settings: translation granule, starting lookup level, effective output address width, input size offset, table base address, VMID, access-flag disable and fault-record flag. It runs every legality rule on that configuration. The result is either a decoded configuration or a bad-entry fault that carries a reason code.

Entries enter through a valid/ready handshake. Each accepted entry produces exactly one result one clock later on a valid/ready output. That result is held while the consumer stalls. When the entry does not enable stage 2, the result is a bypass result that carries only the VMID. The block sits between an entry fetcher and the translation walker, and is stateless apart from its output register.

Top module: `s2_entry_validator`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each entry accepted on in_valid && in_ready gives exactly one result, presented on out_valid in the next cycle and held unchanged while out_ready is 0. in_ready equals !out_valid || out_ready.
- R3: The granule field is word 5 bits 15:14. Code 0 gives 12 granule bits, code 1 gives 16 and code 2 gives 14. Code 3 faults with reason 3.
- R4: The stage-1 enable is word 0 bit 1 and the stage-2 enable is word 0 bit 2. Setting either enable while its capability input is 0 faults with reason 1, which is checked first.
- R5: When stage 2 is not enabled and no fault occurs, out_s2_en is 0 and all decoded fields are 0. out_vmid is word 4 bits 15:0 when cap_s2 is 1, and all ones when cap_s2 is 0.
- R6: The table-format bit is word 5 bit 19; a value of 0 faults with reason 2. The start-level field is word 5 bits 7:6; a value of 3 faults with reason 4. Otherwise the level is 2 minus that field for the 12-bit granule, and 3 minus it for the others.
- R7: The output-size field is word 5 bits 18:16. Codes 0 to 6 mean 32, 36, 40, 42, 44, 48 and 52 bits. The effective code is the smaller of the entry code and cap_oas; an entry code above 6 takes cap_oas, and a cap_oas above 6 means 52 bits.
- R8: The table base is {word 7 bits 19:0, word 6 bits 31:4, 4'b0}. If any base bit at or above the effective output width is set, the entry faults with reason 5.
- R9: The size offset is word 5 bits 5:0. A value above 39 faults with reason 6, and so does a value below the lower limit. The lower limit is 64 minus the output width for the 16-bit granule, and the larger of 16 and that value for the other granules.
- R10: The root index width is 64 minus the offset minus (g + (3 - level) * (g - 3)), where g is the granule bit count. The entry faults with reason 7 when that width exceeds g - 3 by more than 4, that is, when it needs more than 16 concatenated root tables.
- R11: Word 5 bit 20 (big-endian tables) and word 5 bit 26 (stall) each fault with reason 2. The access-flag disable at word 5 bit 21 and the record flag at word 5 bit 27 pass through to out_affd and out_record.
- R12: Stage-2 checks apply in this order: table format, granule, level, base range, size offset, root tables, endianness, stall. The first failing check sets out_reason, and every configuration output, VMID included, is 0 on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry presented |
| in_ready | output | 1 | Entry can be taken this cycle |
| in_entry | input | 256 | Entry words, word k at bits 32k+31:32k |
| cap_s1 | input | 1 | Stage 1 implemented |
| cap_s2 | input | 1 | Stage 2 implemented |
| cap_oas | input | 3 | Maximum output-size code |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 1 | Entry rejected |
| out_reason | output | 3 | Fault reason, 0 when accepted |
| out_s2_en | output | 1 | Stage 2 translates |
| out_vmid | output | 16 | Virtual machine identifier |
| out_gran_bits | output | 5 | Granule size as address bits |
| out_level | output | 2 | Starting lookup level |
| out_oas_bits | output | 6 | Effective output address width |
| out_t0sz | output | 6 | Input size offset |
| out_base | output | 52 | Stage-2 table base address |
| out_affd | output | 1 | Access-flag fault disable |
| out_record | output | 1 | Record faults flag |

## Verification
The block keeps only one register of state, so a wrong decode or a wrong order of checks appears on the result that follows the offending entry one cycle after acceptance. It shows as a wrong reason code, a field that should be zero but is not, or a clamped width that is off by a code. A fault in the output register or the ready logic shows up differently: a result is lost, repeated or altered while out_ready is low, or in_ready drops while the output is free. The scoreboard sees this at the very next transfer. Boundary entries sit exactly on each limit: size offset 39 and 40, the 16 and 64 minus width floors, exactly 16 root tables against 32, and the highest legal base bit.

// File: rtl/s2cv_pkg.sv
package s2cv_pkg;

    localparam int VMID_W   = 16;
    localparam int BASE_W   = 52;
    localparam int T0SZ_W   = 6;
    localparam int OBITS_W  = 6;
    localparam int GBITS_W  = 5;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_STAGE   = 3'd1,
        RSN_FEATURE = 3'd2,
        RSN_GRANULE = 3'd3,
        RSN_LEVEL   = 3'd4,
        RSN_BASE    = 3'd5,
        RSN_SIZE    = 3'd6,
        RSN_CONCAT  = 3'd7
    } reason_e;

    // Raw fields pulled out of the entry words
    typedef struct packed {
        logic                s1_en;
        logic                s2_en;
        logic [VMID_W-1:0]   vmid;
        logic [T0SZ_W-1:0]   t0sz;
        logic [1:0]          sl0;
        logic [1:0]          gran;
        logic [2:0]          oas_code;
        logic                aa64;
        logic                endi;
        logic                affd;
        logic                stall;
        logic                record;
        logic [BASE_W-1:0]   base;
    } raw_fields_t;

    // Decoded result handed to the output register
    typedef struct packed {
        logic                fault;
        reason_e             reason;
        logic                s2_en;
        logic [VMID_W-1:0]   vmid;
        logic [GBITS_W-1:0]  gran_bits;
        logic [1:0]          level;
        logic [OBITS_W-1:0]  oas_bits;
        logic [T0SZ_W-1:0]   t0sz;
        logic [BASE_W-1:0]   base;
        logic                affd;
        logic                record;
    } result_t;

    function automatic logic [OBITS_W-1:0] size_code_bits(input logic [2:0] code);
        logic [OBITS_W-1:0] b;
        unique case (code)
            3'd0:    b = 6'd32;
            3'd1:    b = 6'd36;
            3'd2:    b = 6'd40;
            3'd3:    b = 6'd42;
            3'd4:    b = 6'd44;
            3'd5:    b = 6'd48;
            default: b = 6'd52;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/s2cv_field_split.sv
module s2cv_field_split
    import s2cv_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8
) (
    input  logic [NUM_WORDS*WORD_W-1:0] entry,
    output raw_fields_t                 raw
);
    localparam int CTRL_WORD = 0;
    localparam int VMID_WORD = 4;
    localparam int S2_WORD   = 5;
    localparam int BASE_LO_WORD = 6;
    localparam int BASE_HI_WORD = 7;
    localparam int BASE_LO_W = WORD_W - 4;
    localparam int BASE_HI_W = BASE_W - BASE_LO_W - 4;

    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        assign words[i] = entry[i*WORD_W +: WORD_W];
    end

    logic [WORD_W-1:0] w_ctrl, w_vmid, w_s2, w_blo, w_bhi;
    assign w_ctrl = words[CTRL_WORD];
    assign w_vmid = words[VMID_WORD];
    assign w_s2   = words[S2_WORD];
    assign w_blo  = words[BASE_LO_WORD];
    assign w_bhi  = words[BASE_HI_WORD];

    always_comb begin
        raw          = '0;
        raw.s1_en    = w_ctrl[1];
        raw.s2_en    = w_ctrl[2];
        raw.vmid     = w_vmid[VMID_W-1:0];
        raw.t0sz     = w_s2[5:0];
        raw.sl0      = w_s2[7:6];
        raw.gran     = w_s2[15:14];
        raw.oas_code = w_s2[18:16];
        raw.aa64     = w_s2[19];
        raw.endi     = w_s2[20];
        raw.affd     = w_s2[21];
        raw.stall    = w_s2[26];
        raw.record   = w_s2[27];
        raw.base     = {w_bhi[BASE_HI_W-1:0], w_blo[WORD_W-1:4], 4'b0000};
    end

    logic unused_entry_bits;
    assign unused_entry_bits = ^entry;

endmodule

// File: rtl/s2cv_oas_clamp.sv
module s2cv_oas_clamp
    import s2cv_pkg::*;
(
    input  logic [2:0]         entry_code,
    input  logic [2:0]         cap_code,
    output logic [OBITS_W-1:0] oas_bits
);
    localparam logic [2:0] TOP_CODE = 3'd6;

    logic [2:0] eff_code;

    always_comb begin
        if (entry_code > TOP_CODE)
            eff_code = cap_code;
        else if (entry_code < cap_code)
            eff_code = entry_code;
        else
            eff_code = cap_code;
        oas_bits = size_code_bits(eff_code);
    end

endmodule

// File: rtl/s2cv_geometry.sv
module s2cv_geometry
    import s2cv_pkg::*;
#(
    parameter int MAX_CONCAT_LOG2 = 4
) (
    input  logic [1:0]         gran,
    input  logic [1:0]         sl0,
    input  logic [T0SZ_W-1:0]  t0sz,
    output logic [GBITS_W-1:0] gran_bits,
    output logic [1:0]         level,
    output logic               concat_ok
);
    int g_i, stride_i, lvl_i, span_i, root_w_i, excess_i;

    always_comb begin
        unique case (gran)
            2'd1:    gran_bits = 5'd16;
            2'd2:    gran_bits = 5'd14;
            default: gran_bits = 5'd12;
        endcase
        g_i      = int'(gran_bits);
        stride_i = g_i - 3;
        lvl_i    = ((gran == 2'd0) ? 2 : 3) - int'(sl0);
        level    = 2'(lvl_i);
        // address bits resolved from below the root index down to the page offset
        span_i   = g_i + (3 - lvl_i) * stride_i;
        root_w_i = 64 - int'(t0sz) - span_i;
        // bits beyond one root table must be covered by concatenation
        excess_i = root_w_i - stride_i;
        concat_ok = (excess_i <= MAX_CONCAT_LOG2);
    end

endmodule

// File: rtl/s2cv_rules.sv
module s2cv_rules
    import s2cv_pkg::*;
#(
    parameter int MAX_T0SZ   = 39,
    parameter int MIN_T0SZ_SMALL = 16
) (
    input  raw_fields_t        raw,
    input  logic               cap_s1,
    input  logic               cap_s2,
    input  logic [OBITS_W-1:0] oas_bits,
    input  logic [GBITS_W-1:0] gran_bits,
    input  logic [1:0]         level,
    input  logic               concat_ok,
    output result_t            res
);
    localparam logic [1:0] GRAN_64K = 2'd1;
    localparam logic [1:0] GRAN_BAD = 2'd3;
    localparam logic [1:0] SL0_BAD  = 2'd3;

    logic       stage_bad;
    logic       base_ok;
    logic       size_ok;
    logic [6:0] size_floor;
    reason_e    reason;

    always_comb begin
        stage_bad = (raw.s1_en && !cap_s1) || (raw.s2_en && !cap_s2);
        base_ok   = ((raw.base >> oas_bits) == '0);

        size_floor = 7'd64 - {1'b0, oas_bits};
        if (raw.gran != GRAN_64K && size_floor < 7'(MIN_T0SZ_SMALL))
            size_floor = 7'(MIN_T0SZ_SMALL);
        size_ok = ({1'b0, raw.t0sz} <= 7'(MAX_T0SZ)) && ({1'b0, raw.t0sz} >= size_floor);

        reason = RSN_NONE;
        if (stage_bad)
            reason = RSN_STAGE;
        else if (raw.s2_en) begin
            if (!raw.aa64)               reason = RSN_FEATURE;
            else if (raw.gran == GRAN_BAD) reason = RSN_GRANULE;
            else if (raw.sl0 == SL0_BAD) reason = RSN_LEVEL;
            else if (!base_ok)           reason = RSN_BASE;
            else if (!size_ok)           reason = RSN_SIZE;
            else if (!concat_ok)         reason = RSN_CONCAT;
            else if (raw.endi)           reason = RSN_FEATURE;
            else if (raw.stall)          reason = RSN_FEATURE;
        end

        res        = '0;
        res.reason = reason;
        res.fault  = (reason != RSN_NONE);
        if (!res.fault) begin
            res.s2_en = raw.s2_en;
            res.vmid  = cap_s2 ? raw.vmid : '1;
            if (raw.s2_en) begin
                res.gran_bits = gran_bits;
                res.level     = level;
                res.oas_bits  = oas_bits;
                res.t0sz      = raw.t0sz;
                res.base      = raw.base;
                res.affd      = raw.affd;
                res.record    = raw.record;
            end
        end
    end

endmodule

// File: rtl/s2_entry_validator.sv
module s2_entry_validator
    import s2cv_pkg::*;
#(
    parameter int WORD_W          = 32,
    parameter int NUM_WORDS       = 8,
    parameter int MAX_CONCAT_LOG2 = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [NUM_WORDS*WORD_W-1:0] in_entry,
    input  logic                        cap_s1,
    input  logic                        cap_s2,
    input  logic [2:0]                  cap_oas,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic                        out_fault,
    output logic [2:0]                  out_reason,
    output logic                        out_s2_en,
    output logic [15:0]                 out_vmid,
    output logic [4:0]                  out_gran_bits,
    output logic [1:0]                  out_level,
    output logic [5:0]                  out_oas_bits,
    output logic [5:0]                  out_t0sz,
    output logic [51:0]                 out_base,
    output logic                        out_affd,
    output logic                        out_record
);
    typedef struct packed {
        logic    valid;
        result_t res;
    } state_t;

    raw_fields_t        raw_w;
    logic [OBITS_W-1:0] oas_bits_w;
    logic [GBITS_W-1:0] gran_bits_w;
    logic [1:0]         level_w;
    logic               concat_ok_w;
    result_t            result_w;
    state_t             state_d, state_q;

    s2cv_field_split #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_split (
        .entry (in_entry),
        .raw   (raw_w)
    );

    s2cv_oas_clamp u_clamp (
        .entry_code (raw_w.oas_code),
        .cap_code   (cap_oas),
        .oas_bits   (oas_bits_w)
    );

    s2cv_geometry #(.MAX_CONCAT_LOG2(MAX_CONCAT_LOG2)) u_geom (
        .gran      (raw_w.gran),
        .sl0       (raw_w.sl0),
        .t0sz      (raw_w.t0sz),
        .gran_bits (gran_bits_w),
        .level     (level_w),
        .concat_ok (concat_ok_w)
    );

    s2cv_rules u_rules (
        .raw       (raw_w),
        .cap_s1    (cap_s1),
        .cap_s2    (cap_s2),
        .oas_bits  (oas_bits_w),
        .gran_bits (gran_bits_w),
        .level     (level_w),
        .concat_ok (concat_ok_w),
        .res       (result_w)
    );

    assign in_ready = !state_q.valid || out_ready;

    always_comb begin
        state_d = state_q;
        if (out_ready)
            state_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            state_d.valid = 1'b1;
            state_d.res   = result_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid     = state_q.valid;
    assign out_fault     = state_q.res.fault;
    assign out_reason    = state_q.res.reason;
    assign out_s2_en     = state_q.res.s2_en;
    assign out_vmid      = state_q.res.vmid;
    assign out_gran_bits = state_q.res.gran_bits;
    assign out_level     = state_q.res.level;
    assign out_oas_bits  = state_q.res.oas_bits;
    assign out_t0sz      = state_q.res.t0sz;
    assign out_base      = state_q.res.base;
    assign out_affd      = state_q.res.affd;
    assign out_record    = state_q.res.record;

endmodule

// File: rtl/s2cv_chk.sv
module s2cv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_fault,
    input logic [2:0]  out_reason,
    input logic        out_s2_en,
    input logic [15:0] out_vmid,
    input logic [4:0]  out_gran_bits,
    input logic [5:0]  out_oas_bits,
    input logic [5:0]  out_t0sz,
    input logic [51:0] out_base
);
    // R2
    held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_reason) && $stable(out_vmid) && $stable(out_base));

    // R2
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R12
    fault_zeroes_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_reason != 3'd0 && out_vmid == 16'd0 && !out_s2_en && out_base == 52'd0);

    // R12
    clean_has_no_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault |-> out_reason == 3'd0);

    // R3
    granule_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault && out_s2_en |-> out_gran_bits == 5'd12 || out_gran_bits == 5'd14 || out_gran_bits == 5'd16);

    // R9
    offset_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault && out_s2_en |-> out_t0sz <= 6'd39 && (7'd64 - {1'b0, out_oas_bits}) <= {1'b0, out_t0sz});

    // R8
    base_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault && out_s2_en |-> (out_base >> out_oas_bits) == 52'd0);

endmodule

bind s2_entry_validator s2cv_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_fault     (out_fault),
    .out_reason    (out_reason),
    .out_s2_en     (out_s2_en),
    .out_vmid      (out_vmid),
    .out_gran_bits (out_gran_bits),
    .out_oas_bits  (out_oas_bits),
    .out_t0sz      (out_t0sz),
    .out_base      (out_base)
);

// File: tb/s2_entry_validator_bench.sv
`timescale 1ns/1ps
module s2_entry_validator_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_entry = '0;
    logic         cap_s1 = 1'b1, cap_s2 = 1'b1;
    logic [2:0]   cap_oas = 3'd5;
    logic         out_valid, out_ready = 1'b1;
    logic         out_fault, out_s2_en, out_affd, out_record;
    logic [2:0]   out_reason;
    logic [15:0]  out_vmid;
    logic [4:0]   out_gran_bits;
    logic [1:0]   out_level;
    logic [5:0]   out_oas_bits, out_t0sz;
    logic [51:0]  out_base;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    s2_entry_validator u_s2_entry_validator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_entry(in_entry), .cap_s1(cap_s1), .cap_s2(cap_s2), .cap_oas(cap_oas),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
        .out_reason(out_reason), .out_s2_en(out_s2_en), .out_vmid(out_vmid),
        .out_gran_bits(out_gran_bits), .out_level(out_level), .out_oas_bits(out_oas_bits),
        .out_t0sz(out_t0sz), .out_base(out_base), .out_affd(out_affd), .out_record(out_record)
    );

    typedef struct packed {
        logic s1, s2; logic [15:0] vmid; logic [5:0] t0sz; logic [1:0] sl0, gran;
        logic [2:0] oas; logic aa64, endi, affd, stall, rec; logic [51:0] base;
        logic c1, c2; logic [2:0] coas;
    } tf_t;

    typedef struct {
        logic fault; logic [2:0] reason; logic s2_en; logic [15:0] vmid;
        logic [4:0] gbits; logic [1:0] level; logic [5:0] obits, t0sz;
        logic [51:0] base; logic affd, rec; string tag;
    } exp_t;

    exp_t exp_q[$];

    function automatic tf_t dflt();
        tf_t f;
        f = '0;
        f.s2 = 1; f.vmid = 16'h0a5c; f.t0sz = 6'd24; f.sl0 = 2'd1; f.gran = 2'd0;
        f.oas = 3'd5; f.aa64 = 1; f.base = 52'h0_0012_3450; f.c1 = 1; f.c2 = 1; f.coas = 3'd5;
        return f;
    endfunction

    // Expected result worked out from the requirement text
    function automatic exp_t model(tf_t f);
        exp_t x;
        int g, lvl, ec, ob, ipa, span, extra, lo, rsn;
        int widths[7] = '{32, 36, 40, 42, 44, 48, 52};
        g = (f.gran == 0) ? 12 : (f.gran == 1) ? 16 : 14;
        if (f.oas > 6) ec = int'(f.coas);
        else ec = (f.oas < f.coas) ? int'(f.oas) : int'(f.coas);
        ob = (ec > 6) ? 52 : widths[ec];
        lvl = ((f.gran == 0) ? 2 : 3) - int'(f.sl0);
        ipa = 64 - int'(f.t0sz);
        span = g + (3 - lvl) * (g - 3);
        extra = ipa - span - (g - 3);
        lo = 64 - ob;
        if (f.gran != 1 && lo < 16) lo = 16;
        rsn = 0;
        if ((f.s1 && !f.c1) || (f.s2 && !f.c2)) rsn = 1;
        else if (f.s2) begin
            if (!f.aa64) rsn = 2;
            else if (f.gran == 3) rsn = 3;
            else if (f.sl0 == 3) rsn = 4;
            else if ((f.base >> ob) != 0) rsn = 5;
            else if (int'(f.t0sz) > 39 || int'(f.t0sz) < lo) rsn = 6;
            else if (extra > 4) rsn = 7;
            else if (f.endi || f.stall) rsn = 2;
        end
        x.fault = (rsn != 0); x.reason = 3'(rsn);
        x.s2_en = 0; x.vmid = 0; x.gbits = 0; x.level = 0; x.obits = 0; x.t0sz = 0;
        x.base = 0; x.affd = 0; x.rec = 0; x.tag = "";
        if (rsn == 0) begin
            x.s2_en = f.s2;
            x.vmid = f.c2 ? f.vmid : 16'hffff;
            if (f.s2) begin
                x.gbits = 5'(g); x.level = 2'(lvl); x.obits = 6'(ob); x.t0sz = f.t0sz;
                x.base = f.base; x.affd = f.affd; x.rec = f.rec;
            end
        end
        return x;
    endfunction

    task automatic send(input tf_t f, input string tag);
        logic [255:0] e;
        exp_t x;
        e = '0;
        e[1] = f.s1; e[2] = f.s2;
        e[4*32 +: 16] = f.vmid;
        e[5*32 +: 32] = {4'b0, f.rec, f.stall, 4'b0, f.affd, f.endi, f.aa64, f.oas, f.gran,
                         6'b0, f.sl0, f.t0sz};
        e[6*32 +: 32] = {f.base[31:4], 4'b0};
        e[7*32 +: 32] = {12'b0, f.base[51:32]};
        x = model(f);
        x.tag = tag;
        @(negedge clk);
        in_entry = e; cap_s1 = f.c1; cap_s2 = f.c2; cap_oas = f.coas; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(x);
    endtask

    // Consumer back-pressure, changed just after each rising edge
    initial forever begin
        @(posedge clk);
        #2;
        out_ready = rst_n ? ((cyc % 7 != 3) && (cyc % 11 != 5)) : 1'b1;
        cyc++;
    end

    // Monitor: compares each transferred result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected result reason=%0d expected none", out_reason);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                if (out_fault !== x.fault || out_reason !== x.reason || out_s2_en !== x.s2_en ||
                    out_vmid !== x.vmid || out_gran_bits !== x.gbits || out_level !== x.level ||
                    out_oas_bits !== x.obits || out_t0sz !== x.t0sz || out_base !== x.base ||
                    out_affd !== x.affd || out_record !== x.rec) begin
                    errors++;
                    $display("FAIL %s got f=%0b r=%0d s2=%0b vmid=%h g=%0d l=%0d o=%0d t=%0d b=%h a=%0b rec=%0b expected f=%0b r=%0d s2=%0b vmid=%h g=%0d l=%0d o=%0d t=%0d b=%h a=%0b rec=%0b",
                        x.tag, out_fault, out_reason, out_s2_en, out_vmid, out_gran_bits, out_level,
                        out_oas_bits, out_t0sz, out_base, out_affd, out_record,
                        x.fault, x.reason, x.s2_en, x.vmid, x.gbits, x.level, x.obits, x.t0sz,
                        x.base, x.affd, x.rec);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired, pending=%0d expected 0", exp_q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tf_t f;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end

        // R3 granule decode
        f = dflt(); send(f, "R3 4KB granule");
        f = dflt(); f.gran = 1; f.sl0 = 2; send(f, "R3 64KB granule");
        f = dflt(); f.gran = 2; send(f, "R3 16KB granule at 16 root tables");
        f = dflt(); f.gran = 3; send(f, "R3 granule code 3");
        // R4 capability checks
        f = dflt(); f.s1 = 1; f.c1 = 0; send(f, "R4 stage 1 without capability");
        f = dflt(); f.c2 = 0; send(f, "R4 stage 2 without capability");
        // R5 bypass and VMID
        f = dflt(); f.s2 = 0; f.vmid = 16'h1234; send(f, "R5 bypass keeps VMID");
        f = dflt(); f.s2 = 0; f.c2 = 0; send(f, "R5 no stage 2 gives all-ones VMID");
        f = dflt(); f.s1 = 1; f.s2 = 0; send(f, "R5 stage 1 only bypass");
        // R6 format and level
        f = dflt(); f.aa64 = 0; send(f, "R6 table format 0");
        f = dflt(); f.sl0 = 3; send(f, "R6 start level field 3");
        f = dflt(); f.sl0 = 2; send(f, "R6 4KB level 0");
        // R7 output size clamp
        f = dflt(); f.oas = 6; f.coas = 2; send(f, "R7 clamp to capability 40");
        f = dflt(); f.oas = 7; f.coas = 3; send(f, "R7 code above 6 takes capability");
        f = dflt(); f.oas = 7; f.coas = 7; send(f, "R7 both above 6 gives 52");
        // R8 base range
        f = dflt(); f.oas = 2; f.base = 52'h100_0000_0000; send(f, "R8 base bit 40 over 40-bit width");
        f = dflt(); f.oas = 2; f.base = 52'h080_0000_0000; send(f, "R8 base bit 39 inside width");
        // R9 size offset
        f = dflt(); f.t0sz = 40; send(f, "R9 offset 40");
        f = dflt(); f.oas = 6; f.coas = 6; f.t0sz = 15; f.sl0 = 1; send(f, "R9 4KB floor of 16");
        f = dflt(); f.gran = 1; f.sl0 = 2; f.oas = 6; f.coas = 6; f.t0sz = 12; send(f, "R9 64KB offset 12 legal");
        f = dflt(); f.gran = 1; f.oas = 0; f.t0sz = 31; send(f, "R9 64KB under 64 minus width");
        f = dflt(); f.gran = 1; f.oas = 0; f.t0sz = 32; send(f, "R9 64KB at 64 minus width");
        f = dflt(); f.t0sz = 39; f.sl0 = 0; send(f, "R9 offset 39");
        // R10 concatenation
        f = dflt(); f.t0sz = 21; send(f, "R10 exactly 16 root tables");
        f = dflt(); f.t0sz = 20; send(f, "R10 32 root tables");
        f = dflt(); f.sl0 = 0; send(f, "R10 level 2 with 40-bit input");
        // R11 unsupported modes and pass-through
        f = dflt(); f.endi = 1; send(f, "R11 big-endian tables");
        f = dflt(); f.stall = 1; send(f, "R11 stall mode");
        f = dflt(); f.affd = 1; f.rec = 1; send(f, "R11 flags pass through");
        // R12 priority
        f = dflt(); f.gran = 3; f.stall = 1; send(f, "R12 granule before stall");
        f = dflt(); f.sl0 = 3; f.t0sz = 40; send(f, "R12 level before size");
        f = dflt(); f.aa64 = 0; f.gran = 3; send(f, "R12 format before granule");
        f = dflt(); f.t0sz = 40; f.base = 52'hf_0000_0000_0000; send(f, "R12 base before size");
        @(negedge clk) in_valid = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 extra result out_valid=%0b expected 0", out_valid);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule